// File: doc/BRIEF.md
# SPI Status Flags and Transmit Holding Buffer

This block keeps the status flags of a serial peripheral interface unit and raises its interrupt request. It owns a one-byte transmit holding register in front of the shifter. When the shifter asks for its next byte and the holding register has one, the block hands that byte over and marks the holding register empty again. The shifter itself, the bit clock and the receive path are outside the block. Only their handshake strobes reach it.

Each of the three flags is cleared by a two-step access pattern. First the status register is read while the flag is set, which arms the clear. Later a particular register access completes it. If the flag is set again in between, the armed clear is dropped. An access with no armed clear leaves the flag unchanged. The interrupt request is the OR of the two flags whose enables are set.

Top module: `spi_status_flags`

## Requirements
- R1: The transfer-complete flag sits in status bit 7 and reads 1 on the cycle after a `xfer_done` pulse is sampled.
- R2: The transfer-complete flag returns to 0 after a `stat_rd` that sees it set, followed later by a `data_rd`. A `data_rd` with no such earlier status read leaves it at 1.
- R3: The transmit-empty flag sits in status bit 5 and is 1 out of reset. `load_shifter` is high in the same cycle as `shift_load_req` only if the holding register holds a byte. After each such transfer, the flag reads 1.
- R4: The transmit-empty flag returns to 0 only after a `stat_rd` that sees it set, followed later by a `data_wr`. A `data_wr` without that status read leaves it at 1.
- R5: A `data_wr` stores `data_wdata` in the holding register. If the register is already full, the new byte replaces the old one. The next transfer presents the stored byte on `load_data`.
- R6: The mode-fault flag sits in status bit 4. It reads 1 on the cycle after `ss_n` is sampled going from 1 to 0 while both `master_mode` and `fault_det_en` are 1. Otherwise it does not set.
- R7: The mode-fault flag returns to 0 after a `stat_rd` that sees it set, followed later by a `ctrl1_wr`. A `ctrl1_wr` without that status read leaves it at 1.
- R8: If a flag's set condition occurs after its clear has been armed, the armed clear is discarded. This includes a set condition in the same cycle as the completing access. The flag then stays 1 through the completing access.
- R9: `irq` equals (status bit 7 AND `tc_ie`) OR (status bit 5 AND `txe_ie`), combinationally.
- R10: Status bits 6, 3, 2, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Byte written to the data register |
| ctrl1_wr | input | 1 | Control register 1 write strobe |
| tc_ie | input | 1 | Transfer-complete interrupt enable |
| txe_ie | input | 1 | Transmit-empty interrupt enable |
| master_mode | input | 1 | Unit configured as master |
| fault_det_en | input | 1 | Mode-fault detection enable |
| ss_n | input | 1 | Slave select input, already synchronized |
| xfer_done | input | 1 | Shifter pulse: byte transfer finished |
| shift_load_req | input | 1 | Shifter ready to take the next byte |
| status | output | 8 | Status register value |
| load_shifter | output | 1 | Holding register byte moves to the shifter |
| load_data | output | 8 | Byte handed to the shifter |
| irq | output | 1 | Interrupt request |

## Verification
`load_shifter`, `load_data` and `irq` are combinational. The bench checks them one time step after the inputs are driven and before the capturing edge. Every status bit is a register that updates at the edge sampling its stimulus, so it is checked at the following falling edge, one cycle after the stimulus. The mode-fault detector also registers `ss_n`. A fall is therefore seen on the edge where the low level is first sampled, and the flag follows one cycle after that. The reference model advances once per rising edge, and both groups of outputs are compared on every cycle.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int STAT_W   = 8;
  localparam int NFLAG    = 3;
  // flag slot numbers
  localparam int FL_TC    = 0;
  localparam int FL_TXE   = 1;
  localparam int FL_MF    = 2;
  // status bit positions
  localparam int TC_BIT   = 7;
  localparam int TXE_BIT  = 5;
  localparam int MF_BIT   = 4;
endpackage

// File: rtl/spi_clr_flag.sv
module spi_clr_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic stat_rd,
  input  logic clr_acc,
  output logic flag
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;

  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (set_ev) begin
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else if (arm_q && clr_acc) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (stat_rd && flag_q) begin
      arm_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/spi_tx_hold.sv
module spi_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          load_req,
  output logic          load,
  output logic [DW-1:0] load_data
);
  logic          full_q, full_d;
  logic [DW-1:0] buf_q, buf_d;
  logic          buf_en;

  assign load      = load_req && full_q;
  assign load_data = buf_q;
  assign buf_en    = wr;

  always_comb begin
    full_d = full_q;
    buf_d  = buf_q;
    if (wr) begin
      full_d = 1'b1;
      buf_d  = wdata;
    end else if (load) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= buf_d;
  end
endmodule

// File: rtl/spi_ss_fault.sv
module spi_ss_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic ss_n,
  input  logic master_mode,
  input  logic fault_det_en,
  output logic fault_ev
);
  logic ss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_q <= 1'b1;
    else        ss_q <= ss_n;
  end

  assign fault_ev = ss_q && !ss_n && master_mode && fault_det_en;
endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags
  import spi_stat_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          data_wr,
  input  logic [DW-1:0] data_wdata,
  input  logic          ctrl1_wr,
  input  logic          tc_ie,
  input  logic          txe_ie,
  input  logic          master_mode,
  input  logic          fault_det_en,
  input  logic          ss_n,
  input  logic          xfer_done,
  input  logic          shift_load_req,
  output logic [STAT_W-1:0] status,
  output logic          load_shifter,
  output logic [DW-1:0] load_data,
  output logic          irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             fault_ev;
  logic [NFLAG-1:0] set_vec, clr_vec, flags;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spi_tx_hold #(.DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr        (data_wr),
    .wdata     (data_wdata),
    .load_req  (shift_load_req),
    .load      (load_shifter),
    .load_data (load_data)
  );

  spi_ss_fault u_fault (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .ss_n         (ss_n),
    .master_mode  (master_mode),
    .fault_det_en (fault_det_en),
    .fault_ev     (fault_ev)
  );

  always_comb begin
    set_vec        = '0;
    clr_vec        = '0;
    set_vec[FL_TC]  = xfer_done;
    clr_vec[FL_TC]  = data_rd;
    set_vec[FL_TXE] = load_shifter;
    clr_vec[FL_TXE] = data_wr;
    set_vec[FL_MF]  = fault_ev;
    clr_vec[FL_MF]  = ctrl1_wr;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    spi_clr_flag #(.RST_VAL(i == FL_TXE)) u_flag (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .set_ev  (set_vec[i]),
      .stat_rd (stat_rd),
      .clr_acc (clr_vec[i]),
      .flag    (flags[i])
    );
  end

  always_comb begin
    status          = '0;
    status[TC_BIT]  = flags[FL_TC];
    status[TXE_BIT] = flags[FL_TXE];
    status[MF_BIT]  = flags[FL_MF];
  end

  assign irq = (flags[FL_TC] && tc_ie) || (flags[FL_TXE] && txe_ie);
endmodule

// File: rtl/spi_status_flags_chk.sv
module spi_status_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_rd,
  input logic       data_rd,
  input logic       data_wr,
  input logic       ctrl1_wr,
  input logic       tc_ie,
  input logic       txe_ie,
  input logic       master_mode,
  input logic       fault_det_en,
  input logic       ss_n,
  input logic       xfer_done,
  input logic       shift_load_req,
  input logic [7:0] status,
  input logic       load_shifter,
  input logic       irq
);
  AST_TC_SETS: assert property (@(posedge clk) disable iff (!rst_n) xfer_done |=> status[7]); // R1
  AST_TC_CLR_NEEDS_DRD: assert property (@(posedge clk) disable iff (!rst_n) $fell(status[7]) |-> $past(data_rd)); // R2
  AST_LOAD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) load_shifter |-> shift_load_req); // R3
  AST_TXE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n) load_shifter |=> status[5]); // R3
  AST_TXE_CLR_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n) $fell(status[5]) |-> $past(data_wr)); // R4
  AST_MF_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n) $rose(status[4]) |-> $past(master_mode && fault_det_en && !ss_n)); // R6
  AST_MF_CLR_NEEDS_CR1: assert property (@(posedge clk) disable iff (!rst_n) $fell(status[4]) |-> $past(ctrl1_wr)); // R7
  AST_TC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (xfer_done && data_rd) |=> status[7]); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!tc_ie && !txe_ie) |-> !irq); // R9
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (status & 8'b0100_1111) == 8'h00); // R10
endmodule

bind spi_status_flags spi_status_flags_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .stat_rd        (stat_rd),
  .data_rd        (data_rd),
  .data_wr        (data_wr),
  .ctrl1_wr       (ctrl1_wr),
  .tc_ie          (tc_ie),
  .txe_ie         (txe_ie),
  .master_mode    (master_mode),
  .fault_det_en   (fault_det_en),
  .ss_n           (ss_n),
  .xfer_done      (xfer_done),
  .shift_load_req (shift_load_req),
  .status         (status),
  .load_shifter   (load_shifter),
  .irq            (irq)
);

// File: tb/spi_status_flags_tb.sv
`timescale 1ns/1ps
module spi_status_flags_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stat_rd = 0, data_rd = 0, data_wr = 0, ctrl1_wr = 0;
  logic [7:0] data_wdata = 8'h00;
  logic       tc_ie = 0, txe_ie = 0, master_mode = 0, fault_det_en = 0;
  logic       ss_n = 1, xfer_done = 0, shift_load_req = 0;
  logic [7:0] status, load_data;
  logic       load_shifter, irq;

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  bit m_tc, m_txe, m_mf, a_tc, a_txe, a_mf, m_full, m_ssq;
  bit [7:0] m_buf;

  always #10 clk = ~clk;

  spi_status_flags u_dut (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd),
    .data_wr(data_wr), .data_wdata(data_wdata), .ctrl1_wr(ctrl1_wr),
    .tc_ie(tc_ie), .txe_ie(txe_ie), .master_mode(master_mode),
    .fault_det_en(fault_det_en), .ss_n(ss_n), .xfer_done(xfer_done),
    .shift_load_req(shift_load_req), .status(status),
    .load_shifter(load_shifter), .load_data(load_data), .irq(irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic upd(ref bit f, ref bit a, input bit s, input bit c);
    if (s) begin f = 1; a = 0; end
    else if (a && c) begin f = 0; a = 0; end
    else if (stat_rd && f) a = 1;
  endtask

  task automatic model_reset();
    m_tc = 0; m_txe = 1; m_mf = 0; a_tc = 0; a_txe = 0; a_mf = 0;
    m_full = 0; m_ssq = 1; m_buf = 8'h00;
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic tick();
    bit ld, mfev;
    #1;
    ld = shift_load_req && m_full;
    chk({7'd0, load_shifter}, {7'd0, ld}, "R3 load strobe");
    if (ld) chk(load_data, m_buf, "R5 load byte");
    @(posedge clk);
    mfev = m_ssq && !ss_n && master_mode && fault_det_en;
    upd(m_tc, a_tc, xfer_done, data_rd);
    upd(m_txe, a_txe, ld, data_wr);
    upd(m_mf, a_mf, mfev, ctrl1_wr);
    if (data_wr) begin m_full = 1; m_buf = data_wdata; end
    else if (ld) m_full = 0;
    m_ssq = ss_n;
    @(negedge clk);
    chk({7'd0, status[7]}, {7'd0, m_tc}, "R1 R2 R8 tc flag");
    chk({7'd0, status[5]}, {7'd0, m_txe}, "R3 R4 R8 txe flag");
    chk({7'd0, status[4]}, {7'd0, m_mf}, "R6 R7 mf flag");
    chk(status & 8'h4F, 8'h00, "R10 spare bits");
    chk({7'd0, irq}, {7'd0, (m_tc & tc_ie) | (m_txe & txe_ie)}, "R9 irq");
    stat_rd = 0; data_rd = 0; data_wr = 0; ctrl1_wr = 0;
    xfer_done = 0; shift_load_req = 0;
  endtask

  initial begin
    #(20 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk(status, 8'h20, "R3 reset status");
    chk({7'd0, irq}, 8'h00, "R9 reset irq");
    rst_n = 1;
    repeat (4) @(negedge clk);

    txe_ie = 1; tick();
    chk({7'd0, irq}, 8'h01, "R9 txe irq");
    // unarmed write leaves TXE set
    data_wr = 1; data_wdata = 8'hA5; tick();
    chk(status, 8'h20, "R4 unarmed write");
    shift_load_req = 1; #1;
    chk({7'd0, load_shifter}, 8'h01, "R3 load when full");
    chk(load_data, 8'hA5, "R5 byte handed over");
    tick();
    shift_load_req = 1; #1;
    chk({7'd0, load_shifter}, 8'h00, "R3 no load when empty");
    tick();
    // armed clear of TXE
    stat_rd = 1; tick();
    data_wr = 1; data_wdata = 8'h3C; tick();
    chk(status, 8'h00, "R4 armed write clears");
    chk({7'd0, irq}, 8'h00, "R9 irq drops");
    data_wr = 1; data_wdata = 8'h77; tick();
    shift_load_req = 1; #1;
    chk(load_data, 8'h77, "R5 overwrite");
    tick();
    // transfer-complete
    xfer_done = 1; tick();
    chk({7'd0, status[7]}, 8'h01, "R1 set");
    data_rd = 1; tick();
    chk({7'd0, status[7]}, 8'h01, "R2 unarmed read");
    stat_rd = 1; tick();
    data_rd = 1; tick();
    chk({7'd0, status[7]}, 8'h00, "R2 armed read clears");
    // re-set discards arm
    xfer_done = 1; tick();
    stat_rd = 1; tick();
    xfer_done = 1; tick();
    data_rd = 1; tick();
    chk({7'd0, status[7]}, 8'h01, "R8 arm discarded");
    stat_rd = 1; tick();
    data_rd = 1; xfer_done = 1; tick();
    chk({7'd0, status[7]}, 8'h01, "R8 same-cycle set wins");
    stat_rd = 1; tick(); data_rd = 1; tick();
    // mode fault
    ss_n = 0; tick(); tick();
    chk({7'd0, status[4]}, 8'h00, "R6 slave no fault");
    ss_n = 1; master_mode = 1; tick();
    ss_n = 0; tick(); tick();
    chk({7'd0, status[4]}, 8'h00, "R6 detection off");
    ss_n = 1; fault_det_en = 1; tick();
    ss_n = 0; tick();
    chk({7'd0, status[4]}, 8'h01, "R6 fault sets");
    ctrl1_wr = 1; tick();
    chk({7'd0, status[4]}, 8'h01, "R7 unarmed write");
    stat_rd = 1; tick();
    ctrl1_wr = 1; tick();
    chk({7'd0, status[4]}, 8'h00, "R7 armed write clears");
    ss_n = 1; tick();

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      stat_rd        = ($urandom % 3) == 0;
      data_rd        = ($urandom % 5) == 0;
      data_wr        = ($urandom % 5) == 0;
      data_wdata     = 8'($urandom);
      ctrl1_wr       = ($urandom % 6) == 0;
      xfer_done      = ($urandom % 7) == 0;
      shift_load_req = ($urandom % 4) == 0;
      if (($urandom % 5) == 0) ss_n = ~ss_n;
      if (($urandom % 50) == 0) master_mode = ~master_mode;
      if (($urandom % 50) == 0) fault_det_en = ~fault_det_en;
      if (($urandom % 20) == 0) tc_ie = ~tc_ie;
      if (($urandom % 20) == 0) txe_ie = ~txe_ie;
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule